// File: doc/BRIEF.md
# Dual Wrapping Segment Pointer Counters

This block keeps two 2-bit slice pointers that pick which 16-bit quarter of a 64-bit internal word the next data cycle touches. One pointer serves data reads and the other data writes. Each has a start limit, an end limit and a current value. A one-cycle strobe on a path moves that path's pointer one slice forward, and the pointer returns to its start limit once it has reached its end limit. A current value loaded above the end limit first climbs to slice 3, wraps to slice 0, and keeps climbing to the end limit before the start limit takes effect.

All six fields are written together through one 16-bit configuration word and read back through the same layout. A restart command returns both current values to their start limits and leaves the limits alone. Two full copies of the configuration exist, a foreground copy and a background copy. A bank-select input decides which copy is written, read back, stepped and restarted, and which copy drives the slice outputs.

Each pointer's next move is picked by a small per-cycle decision with five named outcomes: HOLD (no event), LOAD (configuration write), RESTART (restart command), JUMP (a strobe while current equals end, so current takes start) and INC (a strobe otherwise, so current goes up by one modulo 4). The decision follows the priority LOAD, then RESTART, then JUMP or INC, then HOLD.

Top module: `slice_cursor_pair`

## Requirements
- R1: After reset both copies hold start 0, end 3 and current 0 on both pointers. The foreground copy (bank_sel = 0) reads back as 0x18C0, and rd_seg = wr_seg = 0.
- R2: A configuration write loads the active copy from these fields: write start [14:13], write end [12:11], write current [9:8], read end [7:6], read start [4:3], read current [1:0]. Readback uses the same layout, and bits 15, 10, 5 and 2 always read 0 whatever was written to them.
- R3: A read strobe, when the read current differs from the read end, raises the read current by one, modulo 4. A read strobe leaves the write pointer unchanged.
- R4: A read strobe when the read current equals the read end loads the read current with the read start.
- R5: A current value above its end limit steps up to 3, wraps to 0, and keeps stepping until it equals the end limit. Only the strobe after that loads the start limit.
- R6: A write strobe moves the write pointer by the same rules and leaves the read pointer unchanged. Strobes on both paths in one cycle move both pointers.
- R7: A restart loads both current values of the active copy from their start limits and leaves all four limits unchanged.
- R8: When events coincide in one cycle, a configuration write overrides restart and strobes, and a restart overrides strobes.
- R9: Writes, strobes and restarts change only the copy named by bank_sel (0 = foreground, 1 = background). cfg_rdata, rd_seg and wr_seg always show the named copy, and the other copy keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 1 | Active copy: 0 foreground, 1 background |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to load |
| cfg_rdata | output | 16 | Readback of the active copy |
| restart | input | 1 | Reload both current values from their start limits |
| rd_step | input | 1 | Read data cycle strobe |
| wr_step | input | 1 | Write data cycle strobe |
| rd_seg | output | 2 | Slice for the next read data cycle |
| wr_seg | output | 2 | Slice for the next write data cycle |

## Verification
The bench drives a pointer that sits above its end limit all the way round: 3, then 0, then up to the end, then back to start. A design that compared with "greater or equal" would fall to the start limit too early, and one that clamped at 3 would stall. Words with every bit set test the four zero bits, and they catch a packer that echoes written data or shifts a field. The bench also fires a write, a restart and both strobes in the same cycle to find a wrong priority. It then switches banks in the middle of a sequence, to find a shared register or a strobe that leaks into the idle copy.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    localparam int unsigned SEG_W     = 2;
    localparam int unsigned CFG_W     = 16;
    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned NUM_LANES = 2;
    localparam int unsigned LANE_RD   = 0;
    localparam int unsigned LANE_WR   = 1;

    localparam int unsigned WR_START_LSB = 13;
    localparam int unsigned WR_STOP_LSB  = 11;
    localparam int unsigned WR_CUR_LSB   = 8;
    localparam int unsigned RD_STOP_LSB  = 6;
    localparam int unsigned RD_START_LSB = 3;
    localparam int unsigned RD_CUR_LSB   = 0;

    localparam logic [SEG_W-1:0] SEG_LAST = {SEG_W{1'b1}};

    typedef struct packed {
        logic [SEG_W-1:0] start;
        logic [SEG_W-1:0] stop;
        logic [SEG_W-1:0] cur;
    } lane_t;

    localparam lane_t LANE_RESET = '{start: '0, stop: SEG_LAST, cur: '0};

    function automatic lane_t unpack_lane(input logic [CFG_W-1:0] w, input int unsigned lane);
        lane_t l;
        if (lane == LANE_WR) begin
            l.start = w[WR_START_LSB +: SEG_W];
            l.stop  = w[WR_STOP_LSB  +: SEG_W];
            l.cur   = w[WR_CUR_LSB   +: SEG_W];
        end else begin
            l.start = w[RD_START_LSB +: SEG_W];
            l.stop  = w[RD_STOP_LSB  +: SEG_W];
            l.cur   = w[RD_CUR_LSB   +: SEG_W];
        end
        return l;
    endfunction

    function automatic logic [CFG_W-1:0] pack_word(input lane_t rd, input lane_t wr);
        logic [CFG_W-1:0] w;
        w = '0;
        w[WR_START_LSB +: SEG_W] = wr.start;
        w[WR_STOP_LSB  +: SEG_W] = wr.stop;
        w[WR_CUR_LSB   +: SEG_W] = wr.cur;
        w[RD_STOP_LSB  +: SEG_W] = rd.stop;
        w[RD_START_LSB +: SEG_W] = rd.start;
        w[RD_CUR_LSB   +: SEG_W] = rd.cur;
        return w;
    endfunction

    localparam logic [CFG_W-1:0] RB_MASK = pack_word('1, '1);

endpackage

// File: rtl/cursor_lane.sv
module cursor_lane
    import cursor_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  lane_t load_val,
    input  logic  restart,
    input  logic  step,
    output lane_t state_o
);

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_RESTART,
        ACT_JUMP,
        ACT_INC
    } act_e;

    act_e  act;
    lane_t st_q;
    lane_t st_d;

    // Decide this cycle's move; priority LOAD > RESTART > strobe.
    always_comb begin
        if (load)
            act = ACT_LOAD;
        else if (restart)
            act = ACT_RESTART;
        else if (step)
            act = (st_q.cur == st_q.stop) ? ACT_JUMP : ACT_INC;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_HOLD:    st_d = st_q;
            ACT_LOAD:    st_d = load_val;
            ACT_RESTART: st_d.cur = st_q.start;
            ACT_JUMP:    st_d.cur = st_q.start;
            ACT_INC:     st_d.cur = st_q.cur + SEG_W'(1);
            default:     st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= LANE_RESET;
        else
            st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/cursor_bank.sv
module cursor_bank
    import cursor_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             restart,
    input  logic             rd_step,
    input  logic             wr_step,
    output logic [CFG_W-1:0] word_o,
    output logic [SEG_W-1:0] rd_cur,
    output logic [SEG_W-1:0] wr_cur
);

    lane_t lane_st [NUM_LANES];
    logic  lane_step [NUM_LANES];

    assign lane_step[LANE_RD] = active & rd_step;
    assign lane_step[LANE_WR] = active & wr_step;

    for (genvar li = 0; li < NUM_LANES; li++) begin : g_lane
        cursor_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (active & cfg_we),
            .load_val (unpack_lane(cfg_wdata, li)),
            .restart  (active & restart),
            .step     (lane_step[li]),
            .state_o  (lane_st[li])
        );
    end

    assign word_o = pack_word(lane_st[LANE_RD], lane_st[LANE_WR]);
    assign rd_cur = lane_st[LANE_RD].cur;
    assign wr_cur = lane_st[LANE_WR].cur;

endmodule

// File: rtl/slice_cursor_pair.sv
module slice_cursor_pair
    import cursor_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bank_sel,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        restart,
    input  logic        rd_step,
    input  logic        wr_step,
    output logic [1:0]  rd_seg,
    output logic [1:0]  wr_seg
);

    logic [CFG_W-1:0] bank_word [NUM_BANKS];
    logic [SEG_W-1:0] bank_rd   [NUM_BANKS];
    logic [SEG_W-1:0] bank_wr   [NUM_BANKS];

    for (genvar bi = 0; bi < NUM_BANKS; bi++) begin : g_bank
        cursor_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (bank_sel == bi[0]),
            .cfg_we    (cfg_we),
            .cfg_wdata (cfg_wdata),
            .restart   (restart),
            .rd_step   (rd_step),
            .wr_step   (wr_step),
            .word_o    (bank_word[bi]),
            .rd_cur    (bank_rd[bi]),
            .wr_cur    (bank_wr[bi])
        );
    end

    assign cfg_rdata = bank_word[bank_sel];
    assign rd_seg    = bank_rd[bank_sel];
    assign wr_seg    = bank_wr[bank_sel];

endmodule

// File: rtl/cursor_pair_chk.sv
module cursor_pair_chk
    import cursor_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bank_sel,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        restart,
    input logic        rd_step,
    input logic        wr_step,
    input logic [1:0]  rd_seg,
    input logic [1:0]  wr_seg
);

    logic [1:0] rd_stop_f, rd_start_f, wr_stop_f, wr_start_f;
    assign rd_stop_f  = cfg_rdata[RD_STOP_LSB  +: SEG_W];
    assign rd_start_f = cfg_rdata[RD_START_LSB +: SEG_W];
    assign wr_stop_f  = cfg_rdata[WR_STOP_LSB  +: SEG_W];
    assign wr_start_f = cfg_rdata[WR_START_LSB +: SEG_W];

    p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~RB_MASK) == '0);

    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (bank_sel != $past(bank_sel)) || (cfg_rdata == ($past(cfg_wdata) & RB_MASK)));

    p_rd_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !cfg_we && !restart && rd_seg != rd_stop_f)
        |=> (bank_sel != $past(bank_sel)) || (rd_seg == $past(rd_seg) + 2'd1));

    p_rd_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !cfg_we && !restart && rd_seg == rd_stop_f)
        |=> (bank_sel != $past(bank_sel)) || (rd_seg == $past(rd_start_f)));

    p_wr_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !cfg_we && !restart && wr_seg != wr_stop_f)
        |=> (bank_sel != $past(bank_sel)) || (wr_seg == $past(wr_seg) + 2'd1));

    p_wr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_step && !cfg_we && !restart)
        |=> (bank_sel != $past(bank_sel)) || $stable(wr_seg));

    p_rd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_step && !cfg_we && !restart)
        |=> (bank_sel != $past(bank_sel)) || $stable(rd_seg));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !cfg_we)
        |=> (bank_sel != $past(bank_sel)) ||
            (rd_seg == $past(rd_start_f) && wr_seg == $past(wr_start_f) &&
             $stable(rd_stop_f) && $stable(wr_stop_f)));

endmodule

bind slice_cursor_pair cursor_pair_chk i_chk (.*);

// File: tb/test_slice_cursor_pair.sv
module test_slice_cursor_pair;

    // Configuration word layout (R2):
    //   [14:13] write start  [12:11] write end  [9:8] write current
    //   [7:6]   read end     [4:3]   read start [1:0] read current
    //   bits 15, 10, 5, 2 read back as zero.

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        restart = 1'b0;
    logic        rd_step = 1'b0;
    logic        wr_step = 1'b0;
    logic [1:0]  rd_seg;
    logic [1:0]  wr_seg;

    always #2 clk = ~clk;

    slice_cursor_pair i_slice_cursor_pair (.*);

    typedef struct {
        logic [15:0] rdata;
        logic [1:0]  rs;
        logic [1:0]  ws;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Reference state [bank][lane], lane 0 = read, 1 = write.
    logic [1:0] m_start [2][2];
    logic [1:0] m_end   [2][2];
    logic [1:0] m_cur   [2][2];

    function automatic logic [15:0] mk(input logic [1:0] ws, we_, wc, re, rs_, rc);
        return {1'b0, ws, we_, 1'b0, wc, re, 1'b0, rs_, 1'b0, rc};
    endfunction

    function automatic logic [15:0] m_word(input int b);
        return mk(m_start[b][1], m_end[b][1], m_cur[b][1], m_end[b][0], m_start[b][0], m_cur[b][0]);
    endfunction

    function automatic logic [1:0] advance(input logic [1:0] c, e, s);
        return (c == e) ? s : c + 2'd1;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int l = 0; l < 2; l++) begin
                m_start[b][l] = 2'd0; m_end[b][l] = 2'd3; m_cur[b][l] = 2'd0;
            end
    endtask

    task automatic drive(input logic bs, we, input logic [15:0] wd,
                         input logic rsr, rst_, wst, input string req);
        exp_t e;
        int b;
        @(negedge clk);
        bank_sel = bs; cfg_we = we; cfg_wdata = wd;
        restart = rsr; rd_step = rst_; wr_step = wst;
        b = int'(bs);
        if (we) begin
            m_start[b][1] = wd[14:13]; m_end[b][1] = wd[12:11]; m_cur[b][1] = wd[9:8];
            m_end[b][0]   = wd[7:6];   m_start[b][0] = wd[4:3]; m_cur[b][0] = wd[1:0];
        end else if (rsr) begin
            m_cur[b][0] = m_start[b][0]; m_cur[b][1] = m_start[b][1];
        end else begin
            if (rst_) m_cur[b][0] = advance(m_cur[b][0], m_end[b][0], m_start[b][0]);
            if (wst)  m_cur[b][1] = advance(m_cur[b][1], m_end[b][1], m_start[b][1]);
        end
        e.rdata = m_word(b); e.rs = m_cur[b][0]; e.ws = m_cur[b][1]; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input logic bs, input string req);
        drive(bs, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, req);
    endtask

    // Monitor: compares after each active edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (cfg_rdata !== e.rdata || rd_seg !== e.rs || wr_seg !== e.ws) begin
                n_fail++;
                $display("FAIL %s: rdata=%h rd_seg=%0d wr_seg=%0d expected rdata=%h rd_seg=%0d wr_seg=%0d",
                         e.req, cfg_rdata, rd_seg, wr_seg, e.rdata, e.rs, e.ws);
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_vec++;
        if (cfg_rdata !== 16'h18C0 || rd_seg !== 2'd0 || wr_seg !== 2'd0) begin
            n_fail++;
            $display("FAIL R1: rdata=%h rd_seg=%0d wr_seg=%0d expected rdata=18c0 rd_seg=0 wr_seg=0",
                     cfg_rdata, rd_seg, wr_seg);
        end
        // R1: default counting 0..3 then back to 0
        for (int i = 0; i < 5; i++) drive(0, 0, 16'h0, 0, 1, 0, "R1");

        // R2: all-ones write, zero bits forced low
        drive(0, 1, 16'hFFFF, 0, 0, 0, "R2");
        drive(0, 1, 16'h8424, 0, 0, 0, "R2");

        // R3/R4: read start 1, end 2, current 0; write fields left at start0 end3 cur0
        drive(0, 1, mk(2'd0, 2'd3, 2'd0, 2'd2, 2'd1, 2'd0), 0, 0, 0, "R3");
        drive(0, 0, 16'h0, 0, 1, 0, "R3");
        drive(0, 0, 16'h0, 0, 1, 0, "R3");
        drive(0, 0, 16'h0, 0, 1, 0, "R4");
        drive(0, 0, 16'h0, 0, 1, 0, "R4");
        idle(0, "R3");

        // R5: read start 1, end 0, current 2: 3,0,1,2,...
        drive(0, 1, mk(2'd0, 2'd3, 2'd0, 2'd0, 2'd1, 2'd2), 0, 0, 0, "R5");
        for (int i = 0; i < 6; i++) drive(0, 0, 16'h0, 0, 1, 0, "R5");

        // R6: write start 2, end 1, current 3 (above end); read start 0 end 3 cur 1
        drive(0, 1, mk(2'd2, 2'd1, 2'd3, 2'd3, 2'd0, 2'd1), 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) drive(0, 0, 16'h0, 0, 0, 1, "R6");
        for (int i = 0; i < 3; i++) drive(0, 0, 16'h0, 0, 1, 1, "R6");

        // R7: restart
        drive(0, 0, 16'h0, 1, 0, 0, "R7");
        drive(0, 0, 16'h0, 0, 1, 1, "R7");
        drive(0, 0, 16'h0, 1, 0, 0, "R7");

        // R8: collisions
        drive(0, 0, 16'h0, 1, 1, 1, "R8");
        drive(0, 1, mk(2'd1, 2'd2, 2'd3, 2'd1, 2'd3, 2'd2), 1, 1, 1, "R8");
        drive(0, 0, 16'h0, 0, 1, 1, "R8");
        drive(0, 0, 16'h0, 1, 1, 0, "R8");

        // R9: background copy independent of foreground
        idle(1, "R9");
        drive(1, 1, mk(2'd3, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0), 0, 0, 0, "R9");
        drive(1, 0, 16'h0, 0, 1, 1, "R9");
        drive(1, 0, 16'h0, 0, 1, 1, "R9");
        idle(0, "R9");
        drive(0, 0, 16'h0, 0, 1, 0, "R9");
        drive(1, 0, 16'h0, 1, 0, 0, "R9");
        idle(0, "R9");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule